// File: doc/BRIEF.md
# Triggered Sample Window Capture with PRBS Link Check

This block sits behind the deframing logic of one converter channel. It takes 12-bit samples, at most one per clock, and stores them in a circular history of 1024 entries, which is about 4 us at 250 MS/s. Samples are stored only while the upstream frame alignment is reported good. A one-cycle trigger pulse freezes a reference point in that history. The block then streams a window of consecutive samples to a valid/ready readout port. The window starts a programmable number of samples before the trigger and has a programmable length. The final beat carries a marker. Samples that fall after the trigger are sent only once they have been stored.

A link test mode runs a self-synchronising PRBS-7 checker (polynomial x^7 + x^6 + 1) on the incoming words. The checker counts mismatched bits in a saturating counter for bit-error-rate measurement. A trigger that arrives while a window is still being sent is discarded and counted.

Top module: `trig_capture_ring`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, rd_valid_o and rd_last_o are 0, and drop_cnt_o, ber_err_cnt_o and ber_locked_o are 0.
- R2: A sample is stored only in a cycle with aligned_i and smp_valid_i both high. Each stored sample takes the next history address, and the address wraps modulo 1024. Samples presented while alignment is low never appear in a window.
- R3: A trigger accepted while idle sets the window start to the stored sample lying cfg_off_i samples before the sample presented in the trigger cycle (start address = write address at trigger minus offset, modulo 1024). The samples that follow are delivered in storage order.
- R4: A window holds cfg_len_i samples. A length of 0 is treated as 1.
- R5: An offset above 1023 is taken as 1023. The length is then reduced, if needed, so that offset plus length does not exceed 1024. No window carries more than 1024 beats.
- R6: rd_last_o is high on the final beat of a window and on no other beat.
- R7: While rd_valid_o is high and rd_ready_i is low, rd_valid_o stays high, and rd_data_o and rd_last_o hold their values. No sample is lost or repeated.
- R8: A window sample that lies at or after the trigger point is emitted only after it has been stored. If samples arrive slowly, the readout pauses.
- R9: A trigger that arrives from acceptance until the final beat is taken is ignored. Each such trigger increments drop_cnt_o by one, and the counter saturates at its maximum.
- R10: With ber_mode_i high, each stored word is checked MSB first, each bit against the XOR of the bits received 6 and 7 positions earlier. ber_locked_o rises after the first checked word. From then on, ber_err_cnt_o adds the mismatches of each word and saturates at all ones. A single flipped bit in the stream adds exactly 3.
- R11: With ber_mode_i low, ber_err_cnt_o and ber_locked_o are 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aligned_i | input | 1 | Upstream frame alignment achieved |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_data_i | input | 12 | Sample word |
| trig_i | input | 1 | Trigger pulse |
| cfg_off_i | input | 11 | Pre-trigger offset in samples |
| cfg_len_i | input | 11 | Window length in samples |
| ber_mode_i | input | 1 | Enable PRBS bit-error checking |
| rd_ready_i | input | 1 | Readout sink ready |
| rd_valid_o | output | 1 | Readout beat valid |
| rd_data_o | output | 12 | Readout sample |
| rd_last_o | output | 1 | Final beat of window |
| drop_cnt_o | output | 16 | Count of discarded triggers |
| ber_locked_o | output | 1 | PRBS checker synchronised |
| ber_err_cnt_o | output | 32 | Saturating bit-error count |

## Verification
The properties assume that the sink does not need data to stay meaningful across a reset. They also assume that the history already holds at least cfg_off_i samples when a trigger arrives, and that a stalled sink drains a window before newer writes overwrite its oldest entries. The stimulus holds off triggers until more than 1024 samples have been written. It keeps every stall pattern short relative to the window, so no window entry is overwritten before it is read. PRBS words are fed only after the mode is switched on. Flips are injected well after lock, so the three mismatches caused by each flip are all counted.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_RUN  = 1'b1
  } win_state_e;
endpackage

// File: rtl/tcr_ring_mem.sv
module tcr_ring_mem #(
  parameter int DW    = 12,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] store_q [DEPTH];

  // Read enable holds rdata_o, so it can drive the readout port directly.
  always_ff @(posedge clk) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= store_q[raddr_i];
  end
endmodule

// File: rtl/tcr_window_ctrl.sv
module tcr_window_ctrl
  import tcr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int DROP_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  output logic [AW-1:0]     wr_addr_o,
  input  logic              trig_i,
  input  logic [CW-1:0]     cfg_off_i,
  input  logic [CW-1:0]     cfg_len_i,
  input  logic              rd_ready_i,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_raddr_o,
  output logic              rd_valid_o,
  output logic              rd_last_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int VW = CW + 1;

  win_state_e        state_q, state_n;
  logic [AW-1:0]     wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]     remain_q, remain_n;
  logic [VW-1:0]     avail_q, avail_n;
  logic              valid_q, valid_n, last_q, last_n;
  logic [DROP_W-1:0] drop_q, drop_n;

  logic [CW-1:0] off_c, len_nz, room, len_c;
  logic          trig_take, trig_drop, issue, beat;

  // Clamp window so that offset + length never exceeds the history depth.
  always_comb begin
    off_c  = (cfg_off_i > CW'(DEPTH - 1)) ? CW'(DEPTH - 1) : cfg_off_i;
    len_nz = (cfg_len_i == '0) ? CW'(1) : cfg_len_i;
    room   = CW'(DEPTH) - off_c;
    len_c  = (len_nz > room) ? room : len_nz;
  end

  assign trig_take = trig_i && (state_q == WIN_IDLE);
  assign trig_drop = trig_i && (state_q == WIN_RUN);
  assign beat      = valid_q && rd_ready_i;
  assign issue     = (state_q == WIN_RUN) && (remain_q != '0) && (avail_q != '0)
                     && (!valid_q || rd_ready_i);

  always_comb begin
    state_n  = state_q;
    wp_n     = wp_q;
    rp_n     = rp_q;
    remain_n = remain_q;
    avail_n  = avail_q;
    valid_n  = valid_q;
    last_n   = last_q;
    drop_n   = drop_q;
    if (wr_en_i) wp_n = wp_q + 1'b1;
    if (trig_take) begin
      state_n  = WIN_RUN;
      rp_n     = wp_q - off_c[AW-1:0];
      remain_n = len_c;
      avail_n  = VW'(off_c) + VW'(wr_en_i);
    end else if (state_q == WIN_RUN) begin
      if (issue) begin
        rp_n     = rp_q + 1'b1;
        remain_n = remain_q - 1'b1;
      end
      avail_n = avail_q + VW'(wr_en_i && !(&avail_q)) - VW'(issue);
      if (beat && last_q) state_n = WIN_IDLE;
    end
    if (issue) begin
      valid_n = 1'b1;
      last_n  = (remain_q == CW'(1));
    end else if (beat) begin
      valid_n = 1'b0;
      last_n  = 1'b0;
    end
    if (trig_drop && (drop_q != '1)) drop_n = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WIN_IDLE;
      wp_q     <= '0;
      rp_q     <= '0;
      remain_q <= '0;
      avail_q  <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      drop_q   <= '0;
    end else begin
      state_q  <= state_n;
      wp_q     <= wp_n;
      rp_q     <= rp_n;
      remain_q <= remain_n;
      avail_q  <= avail_n;
      valid_q  <= valid_n;
      last_q   <= last_n;
      drop_q   <= drop_n;
    end
  end

  assign wr_addr_o   = wp_q;
  assign mem_re_o    = issue;
  assign mem_raddr_o = rp_q;
  assign rd_valid_o  = valid_q;
  assign rd_last_o   = last_q;
  assign drop_cnt_o  = drop_q;
endmodule

// File: rtl/tcr_prbs_chk.sv
module tcr_prbs_chk #(
  parameter int DW    = 12,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             word_vld_i,
  input  logic [DW-1:0]    word_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int EW    = $clog2(DW + 1);
  localparam int TAP_A = 5;
  localparam int TAP_B = 6;

  logic [6:0]       hist_q, hist_n, h;
  logic             lock_q, lock_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [EW-1:0]    nerr;
  logic [CNT_W:0]   sum;

  // Bit-serial prediction unrolled over one word, MSB first.
  always_comb begin
    h    = hist_q;
    nerr = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      nerr = nerr + EW'(word_i[i] ^ h[TAP_A] ^ h[TAP_B]);
      h    = {h[5:0], word_i[i]};
    end
  end

  assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(nerr);

  always_comb begin
    hist_n = hist_q;
    lock_n = lock_q;
    cnt_n  = cnt_q;
    if (!en_i) begin
      lock_n = 1'b0;
      cnt_n  = '0;
    end else if (word_vld_i) begin
      hist_n = h;
      lock_n = 1'b1;
      if (lock_q) cnt_n = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hist_q <= hist_n;
      lock_q <= lock_n;
      cnt_q  <= cnt_n;
    end
  end

  assign locked_o  = lock_q;
  assign err_cnt_o = cnt_q;
endmodule

// File: rtl/trig_capture_ring.sv
module trig_capture_ring #(
  parameter int SMP_W  = 12,
  parameter int DEPTH  = 1024,
  parameter int DROP_W = 16,
  parameter int BER_W  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aligned_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  input  logic              trig_i,
  input  logic [CW-1:0]     cfg_off_i,
  input  logic [CW-1:0]     cfg_len_i,
  input  logic              ber_mode_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [SMP_W-1:0]  rd_data_o,
  output logic              rd_last_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  output logic              ber_locked_o,
  output logic [BER_W-1:0]  ber_err_cnt_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          wr_en, mem_re;
  logic [AW-1:0] wr_addr, mem_raddr;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign wr_en = aligned_i && smp_valid_i;

  tcr_ring_mem #(.DW(SMP_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (smp_data_i),
    .re_i    (mem_re),
    .raddr_i (mem_raddr),
    .rdata_o (rd_data_o)
  );

  tcr_window_ctrl #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en_i     (wr_en),
    .wr_addr_o   (wr_addr),
    .trig_i      (trig_i),
    .cfg_off_i   (cfg_off_i),
    .cfg_len_i   (cfg_len_i),
    .rd_ready_i  (rd_ready_i),
    .mem_re_o    (mem_re),
    .mem_raddr_o (mem_raddr),
    .rd_valid_o  (rd_valid_o),
    .rd_last_o   (rd_last_o),
    .drop_cnt_o  (drop_cnt_o)
  );

  tcr_prbs_chk #(.DW(SMP_W), .CNT_W(BER_W)) u_prbs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .en_i       (ber_mode_i),
    .word_vld_i (wr_en),
    .word_i     (smp_data_i),
    .locked_o   (ber_locked_o),
    .err_cnt_o  (ber_err_cnt_o)
  );
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
  parameter int SMP_W  = 12,
  parameter int DEPTH  = 1024,
  parameter int DROP_W = 16,
  parameter int BER_W  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ber_mode_i,
  input logic              rd_ready_i,
  input logic              rd_valid_o,
  input logic [SMP_W-1:0]  rd_data_o,
  input logic              rd_last_o,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic              ber_locked_o,
  input logic [BER_W-1:0]  ber_err_cnt_o
);
  logic [AW:0] beats_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats_q <= '0;
    else if (rd_valid_o && rd_ready_i) beats_q <= rd_last_o ? '0 : beats_q + 1'b1;
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last_o |-> rd_valid_o); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o))); // R7

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && rd_ready_i) |-> (beats_q < (AW+1)'(DEPTH))); // R5

  AST_DROP_NO_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt_o >= $past(drop_cnt_o)); // R9

  AST_BER_NO_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (ber_mode_i && $past(ber_mode_i)) |-> (ber_err_cnt_o >= $past(ber_err_cnt_o))); // R10

  AST_BER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !ber_mode_i |=> ((ber_err_cnt_o == '0) && !ber_locked_o)); // R11
endmodule

bind trig_capture_ring tcr_checker #(
  .SMP_W(SMP_W), .DEPTH(DEPTH), .DROP_W(DROP_W), .BER_W(BER_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ber_mode_i    (ber_mode_i),
  .rd_ready_i    (rd_ready_i),
  .rd_valid_o    (rd_valid_o),
  .rd_data_o     (rd_data_o),
  .rd_last_o     (rd_last_o),
  .drop_cnt_o    (drop_cnt_o),
  .ber_locked_o  (ber_locked_o),
  .ber_err_cnt_o (ber_err_cnt_o)
);

// File: tb/trig_capture_ring_tb_top.sv
`timescale 1ns/1ps
module trig_capture_ring_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aligned_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_data_i = 12'h000;
  logic        trig_i = 1'b0;
  logic [10:0] cfg_off_i = 11'd0;
  logic [10:0] cfg_len_i = 11'd1;
  logic        ber_mode_i = 1'b0;
  logic        rd_ready_i = 1'b1;
  logic        rd_valid_o, rd_last_o, ber_locked_o;
  logic [11:0] rd_data_o;
  logic [15:0] drop_cnt_o;
  logic [31:0] ber_err_cnt_o;

  always #4 clk = ~clk;

  trig_capture_ring dut_i (
    .clk(clk), .rst_n(rst_n), .aligned_i(aligned_i), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .trig_i(trig_i), .cfg_off_i(cfg_off_i),
    .cfg_len_i(cfg_len_i), .ber_mode_i(ber_mode_i), .rd_ready_i(rd_ready_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_last_o(rd_last_o),
    .drop_cnt_o(drop_cnt_o), .ber_locked_o(ber_locked_o), .ber_err_cnt_o(ber_err_cnt_o)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0, wcnt = 0, gcount = 0, tindex = 0;
  int vdiv = 1, rdy_mode = 0;
  bit gen_on = 0, prbs_on = 0, done = 0;
  logic [11:0] got [2048];
  bit          gl  [2048];
  logic [6:0]  gst = 7'b1010011;
  int          pbit = 0, flip_at = -1;

  function automatic logic [11:0] val(int n);
    return 12'((n * 37 + 5) & 32'hFFF);
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && aligned_i && smp_valid_i) wcnt++;

  // Drives ready and samples, and records handshakes before the next edge.
  always @(negedge clk) begin
    logic [11:0] w;
    cyc++;
    rd_ready_i = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (rd_valid_o && rd_ready_i && gcount < 2048) begin
      got[gcount] = rd_data_o;
      gl[gcount]  = rd_last_o;
      gcount++;
    end
    if (gen_on && (cyc % vdiv) == 0) begin
      smp_valid_i = 1'b1;
      if (prbs_on) begin
        for (int i = 11; i >= 0; i--) begin
          gst  = {gst[5:0], gst[5] ^ gst[6]};
          w[i] = gst[0] ^ (pbit == flip_at);
          pbit++;
        end
        smp_data_i = w;
      end else begin
        smp_data_i = aligned_i ? val(wcnt) : 12'hABC;
      end
    end else begin
      smp_valid_i = 1'b0;
      smp_data_i  = 12'hABC;
    end
  end

  task automatic pulse_trig();
    @(negedge clk); trig_i = 1'b1;
    @(negedge clk); trig_i = 1'b0;
  endtask

  task automatic launch(int off, int len);
    @(negedge clk);
    cfg_off_i = 11'(off); cfg_len_i = 11'(len); gcount = 0;
    @(negedge clk);
    trig_i = 1'b1; tindex = wcnt;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic verify(int exp_off, int exp_len, string tag);
    int t = 0; int bad = -1; int nl = 0;
    while (gcount < exp_len && t < 6000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    check(gcount == exp_len, {tag, " R4 window beat count"}, gcount, exp_len);
    for (int i = 0; i < exp_len && i < gcount; i++) begin
      if (bad < 0 && got[i] !== val(tindex - exp_off + i)) bad = i;
      if (gl[i]) nl++;
    end
    if (bad >= 0)
      check(0, {tag, " sample content"}, got[bad], val(tindex - exp_off + bad));
    else
      check(1, tag, 0, 0);
    check(nl == 1 && gcount >= 1 && gl[exp_len-1], {tag, " R6 last marker"}, nl, 1);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check(!rd_valid_o && !rd_last_o, "R1 readout idle in reset", rd_valid_o, 0);
    check(drop_cnt_o == 0 && ber_err_cnt_o == 0 && !ber_locked_o, "R1 counters in reset",
          drop_cnt_o + ber_err_cnt_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_valid_o && drop_cnt_o == 0 && !ber_locked_o, "R1 state after release", rd_valid_o, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_fill_basic();
    aligned_i = 1'b1; gen_on = 1;
    repeat (1200) @(negedge clk);
    launch(8, 16);
    verify(8, 16, "R3 basic window");
  endtask

  task automatic t_wrap();
    while (wcnt < 2045) @(negedge clk);
    launch(20, 30);
    verify(20, 30, "R2 R3 window across address wrap");
  endtask

  task automatic t_stall();
    rdy_mode = 1;
    launch(100, 200);
    verify(100, 200, "R7 window under sink stalls");
    rdy_mode = 0;
  endtask

  task automatic t_post();
    vdiv = 3;
    launch(2, 40);
    verify(2, 40, "R8 post-trigger samples with slow input");
    vdiv = 1;
  endtask

  task automatic t_clamp();
    launch(5, 0);
    verify(5, 1, "R4 zero length");
    launch(1000, 100);
    verify(1000, 24, "R5 length clamped");
    launch(1500, 10);
    verify(1023, 1, "R5 offset clamped");
  endtask

  task automatic t_align();
    @(negedge clk); aligned_i = 1'b0;
    repeat (25) @(negedge clk);
    aligned_i = 1'b1;
    repeat (10) @(negedge clk);
    launch(30, 20);
    verify(30, 20, "R2 unaligned samples skipped");
  endtask

  task automatic t_drop();
    longint d0 = drop_cnt_o;
    rdy_mode = 1;
    launch(50, 80);
    repeat (3) @(negedge clk);
    pulse_trig();
    repeat (4) @(negedge clk);
    pulse_trig();
    verify(50, 80, "R9 window unaffected by late triggers");
    check(drop_cnt_o == d0 + 2, "R9 dropped trigger count", drop_cnt_o, d0 + 2);
    rdy_mode = 0;
  endtask

  task automatic t_ber();
    gen_on = 0;
    @(negedge clk); prbs_on = 1; ber_mode_i = 1'b1;
    repeat (4) @(negedge clk);
    check(!ber_locked_o, "R10 not locked before first word", ber_locked_o, 0);
    gen_on = 1;
    repeat (4) @(negedge clk);
    check(ber_locked_o, "R10 locked after first word", ber_locked_o, 1);
    repeat (30) @(negedge clk);
    check(ber_err_cnt_o == 0, "R10 clean PRBS has no errors", ber_err_cnt_o, 0);
    flip_at = pbit + 60;
    repeat (30) @(negedge clk);
    check(ber_err_cnt_o == 3, "R10 single flip gives three mismatches", ber_err_cnt_o, 3);
    flip_at = pbit + 60;
    repeat (30) @(negedge clk);
    check(ber_err_cnt_o == 6, "R10 second flip accumulates", ber_err_cnt_o, 6);
    ber_mode_i = 1'b0;
    repeat (2) @(negedge clk);
    check(ber_err_cnt_o == 0 && !ber_locked_o, "R11 mode off clears", ber_err_cnt_o, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_fill_basic();
    t_wrap();
    t_stall();
    t_post();
    t_clamp();
    t_align();
    t_drop();
    t_ber();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule